// File: doc/BRIEF.md
# Message-Signalled Interrupt Capture and Aggregation Unit

This unit sits behind a PCIe root port. It receives inbound memory writes that carry message-signalled interrupts and turns them into one interrupt line for the CPU. Vectors are grouped into sets of 32. Each set owns a 64-bit capture address that software programs. A write whose address equals a set's capture address latches one pending bit in that set's status word. The low five bits of the write data select that bit.

A two-level status tree combines the pending bits. Each set has a summary bit in a top-level status word, and that bit follows the set's enabled pending vectors. Four legacy wire-style interrupts are modelled as level sources. An assert message raises a source and a deassert message drops it. The matching top-level bit stays set while the source is high, and software can clear it only after the source has dropped. The CPU line is the registered OR of all enabled top-level bits.

Software reaches every control and status word through a simple word-wide register port. A write strobe takes effect at the clock edge, and read data is a pure decode of the address.

Top module: `msi_irq_agg`

## Requirements
- R1: After reset every register reads zero and irq_o is low.
- R2: An inbound write whose 64-bit address equals set s's {high word, low word} capture address, while set s is enabled, sets bit (data mod 32) of set s's status word. The bit reads back in the cycle after the capturing edge.
- R3: An inbound write is dropped without effect if its address matches no set, or if it matches a set whose enable bit at 0x190 is zero.
- R4: Writing ones to a set's status word (set base + 0x4) clears those bits. A capture into the same bit at the same edge wins over the clear.
- R5: Top-level status bit 8+s is raised one edge after set s has a pending vector whose enable bit (set base + 0x8) is one. A pending vector whose enable bit is zero raises nothing.
- R6: Writing a one to top-level status bit 8+s (0x184) clears it at that edge. If an enabled vector of set s is still pending, the bit is set again at the next edge.
- R7: An assert pulse on intx_assert_i[k] sets top-level status bit 24+k one edge after the level rises. A clear of that bit has no effect while the level is high. After a deassert pulse the bit holds until it is cleared, and a clear then removes it.
- R8: irq_o is the registered OR of (top-level status AND top-level enable at 0x180), one edge behind. Status bits whose enable is zero do not drive it.
- R9: Only bits 8 to 8+N_SETS-1 and 24 to 27 of the top-level enable are stored, and only bits 0 to N_SETS-1 of the set-enable word at 0x190. All other bits read zero.
- R10: Set s places its capture address low word at 0xC00+0x10*s and its high word at 0xC80+4*s. Both are readable and writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, decoded from reg_addr_i |
| msi_valid_i | input | 1 | Inbound message write valid |
| msi_addr_i | input | 64 | Inbound message write address |
| msi_data_i | input | 32 | Inbound message write data; bits 4:0 select the vector |
| intx_assert_i | input | 4 | Per-source assert message strobes |
| intx_deassert_i | input | 4 | Per-source deassert message strobes |
| irq_o | output | 1 | Aggregated CPU interrupt |

## Verification
A wrong status bit inside a set shows on a readback of that set in the very next cycle. It also shows as a summary bit rising or failing to rise one edge later, and on irq_o one edge after that. Mistakes in clear priority are visible at once: a top-level bit reads zero for exactly one cycle and then returns, or a level source bit fails to survive a clear. The scoreboard pins every check to an exact cycle count from the stimulus, so an extra or missing pipeline stage is reported as a mismatch.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int unsigned REG_AW      = 12;
  localparam int unsigned REG_DW      = 32;
  localparam int unsigned VEC_PER_SET = 32;
  localparam int unsigned VEC_IDX_W   = $clog2(VEC_PER_SET);
  localparam int unsigned INTX_NUM    = 4;
  localparam int unsigned SET_STRIDE  = 16;
  localparam int unsigned HI_STRIDE   = 4;
  localparam int unsigned SET_LSB_POS = 8;
  localparam int unsigned INTX_LSB_POS = 24;

  localparam logic [REG_AW-1:0] TOP_EN_OFS  = 12'h180;
  localparam logic [REG_AW-1:0] TOP_ST_OFS  = 12'h184;
  localparam logic [REG_AW-1:0] SET_EN_OFS  = 12'h190;
  localparam logic [REG_AW-1:0] SET_BASE_OFS = 12'hC00;
  localparam logic [REG_AW-1:0] HI_BASE_OFS  = 12'hC80;

  typedef struct packed {
    logic                 valid;
    logic [63:0]          addr;
    logic [VEC_IDX_W-1:0] vec;
  } msi_wr_t;

  function automatic logic [REG_DW-1:0] top_mask(int unsigned n_sets);
    logic [REG_DW-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < n_sets; i++) m[SET_LSB_POS+i] = 1'b1;
    for (int unsigned k = 0; k < INTX_NUM; k++) m[INTX_LSB_POS+k] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/msi_set_bank.sv
module msi_set_bank
  import msi_agg_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   set_en_i,
  input  msi_wr_t                msi_i,
  input  logic                   wr_lo_i,
  input  logic                   wr_hi_i,
  input  logic                   wr_stat_i,
  input  logic                   wr_ena_i,
  input  logic [REG_DW-1:0]      wdata_i,
  output logic [REG_DW-1:0]      addr_lo_o,
  output logic [REG_DW-1:0]      addr_hi_o,
  output logic [VEC_PER_SET-1:0] stat_o,
  output logic [VEC_PER_SET-1:0] ena_o,
  output logic                   pend_o
);
  logic [REG_DW-1:0]      lo_q, hi_q;
  logic [VEC_PER_SET-1:0] stat_q, ena_q, set_vec, clr_vec;
  logic                   hit;

  assign hit     = msi_i.valid && set_en_i && (msi_i.addr == {hi_q, lo_q});
  assign set_vec = hit ? (VEC_PER_SET'(1) << msi_i.vec) : '0;
  assign clr_vec = wr_stat_i ? wdata_i[VEC_PER_SET-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lo_q   <= '0;
      hi_q   <= '0;
      stat_q <= '0;
      ena_q  <= '0;
    end else begin
      if (wr_lo_i)  lo_q  <= wdata_i;
      if (wr_hi_i)  hi_q  <= wdata_i;
      if (wr_ena_i) ena_q <= wdata_i[VEC_PER_SET-1:0];
      // capture wins over a same-edge clear
      stat_q <= (stat_q & ~clr_vec) | set_vec;
    end
  end

  assign addr_lo_o = lo_q;
  assign addr_hi_o = hi_q;
  assign stat_o    = stat_q;
  assign ena_o     = ena_q;
  assign pend_o    = |(stat_q & ena_q);
endmodule

// File: rtl/msi_intx_level.sv
module msi_intx_level
  import msi_agg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [INTX_NUM-1:0] assert_i,
  input  logic [INTX_NUM-1:0] deassert_i,
  output logic [INTX_NUM-1:0] lvl_o
);
  logic [INTX_NUM-1:0] lvl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= '0;
    else         lvl_q <= (lvl_q & ~deassert_i) | assert_i;
  end

  assign lvl_o = lvl_q;
endmodule

// File: rtl/msi_top_status.sv
module msi_top_status
  import msi_agg_pkg::*;
#(
  parameter int unsigned N_SETS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [N_SETS-1:0]   set_pend_i,
  input  logic [INTX_NUM-1:0] intx_lvl_i,
  input  logic                en_wr_i,
  input  logic                st_wr_i,
  input  logic [REG_DW-1:0]   wdata_i,
  output logic [REG_DW-1:0]   top_st_o,
  output logic [REG_DW-1:0]   top_en_o,
  output logic                irq_o
);
  localparam logic [REG_DW-1:0] MASK = top_mask(N_SETS);

  logic [REG_DW-1:0] st_q, st_d, en_q, clr;
  logic              irq_q;

  assign clr = st_wr_i ? wdata_i : '0;

  always_comb begin
    st_d = '0;
    for (int unsigned i = 0; i < N_SETS; i++) begin
      // clear first, re-raise from pending on the following edge
      if (clr[SET_LSB_POS+i])     st_d[SET_LSB_POS+i] = 1'b0;
      else if (set_pend_i[i])     st_d[SET_LSB_POS+i] = 1'b1;
      else                        st_d[SET_LSB_POS+i] = st_q[SET_LSB_POS+i];
    end
    for (int unsigned k = 0; k < INTX_NUM; k++) begin
      // level source blocks the clear
      if (intx_lvl_i[k])          st_d[INTX_LSB_POS+k] = 1'b1;
      else if (clr[INTX_LSB_POS+k]) st_d[INTX_LSB_POS+k] = 1'b0;
      else                        st_d[INTX_LSB_POS+k] = st_q[INTX_LSB_POS+k];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= '0;
      en_q  <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      if (en_wr_i) en_q <= wdata_i & MASK;
      irq_q <= |(st_q & en_q);
    end
  end

  assign top_st_o = st_q;
  assign top_en_o = en_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/msi_irq_agg.sv
module msi_irq_agg
  import msi_agg_pkg::*;
#(
  parameter int unsigned N_SETS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    reg_we_i,
  input  logic [REG_AW-1:0]       reg_addr_i,
  input  logic [REG_DW-1:0]       reg_wdata_i,
  output logic [REG_DW-1:0]       reg_rdata_o,
  input  logic                    msi_valid_i,
  input  logic [63:0]             msi_addr_i,
  input  logic [REG_DW-1:0]       msi_data_i,
  input  logic [INTX_NUM-1:0]     intx_assert_i,
  input  logic [INTX_NUM-1:0]     intx_deassert_i,
  output logic                    irq_o
);
  localparam int unsigned FLAT_W = N_SETS * VEC_PER_SET;

  msi_wr_t                msi;
  logic [N_SETS-1:0]      set_en_q, set_pend, set_clr;
  logic [REG_DW-1:0]      lo [N_SETS];
  logic [REG_DW-1:0]      hi [N_SETS];
  logic [VEC_PER_SET-1:0] stat [N_SETS];
  logic [VEC_PER_SET-1:0] ena [N_SETS];
  logic [FLAT_W-1:0]      stat_flat;
  logic [INTX_NUM-1:0]    intx_lvl;
  logic [REG_DW-1:0]      top_st, top_en;
  logic                   unused_data;

  assign msi.valid   = msi_valid_i;
  assign msi.addr    = msi_addr_i;
  assign msi.vec     = msi_data_i[VEC_IDX_W-1:0];
  assign unused_data = ^msi_data_i[REG_DW-1:VEC_IDX_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) set_en_q <= '0;
    else if (reg_we_i && reg_addr_i == SET_EN_OFS) set_en_q <= reg_wdata_i[N_SETS-1:0];
  end

  for (genvar i = 0; i < N_SETS; i++) begin : g_set
    localparam logic [REG_AW-1:0] OFS_LO = SET_BASE_OFS + REG_AW'(SET_STRIDE * i);
    localparam logic [REG_AW-1:0] OFS_ST = OFS_LO + REG_AW'(4);
    localparam logic [REG_AW-1:0] OFS_EN = OFS_LO + REG_AW'(8);
    localparam logic [REG_AW-1:0] OFS_HI = HI_BASE_OFS + REG_AW'(HI_STRIDE * i);

    msi_set_bank u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .set_en_i  (set_en_q[i]),
      .msi_i     (msi),
      .wr_lo_i   (reg_we_i && reg_addr_i == OFS_LO),
      .wr_hi_i   (reg_we_i && reg_addr_i == OFS_HI),
      .wr_stat_i (reg_we_i && reg_addr_i == OFS_ST),
      .wr_ena_i  (reg_we_i && reg_addr_i == OFS_EN),
      .wdata_i   (reg_wdata_i),
      .addr_lo_o (lo[i]),
      .addr_hi_o (hi[i]),
      .stat_o    (stat[i]),
      .ena_o     (ena[i]),
      .pend_o    (set_pend[i])
    );

    assign stat_flat[i*VEC_PER_SET +: VEC_PER_SET] = stat[i];
    assign set_clr[i] = reg_we_i && reg_addr_i == TOP_ST_OFS && reg_wdata_i[SET_LSB_POS+i];
  end

  msi_intx_level u_intx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .assert_i   (intx_assert_i),
    .deassert_i (intx_deassert_i),
    .lvl_o      (intx_lvl)
  );

  msi_top_status #(.N_SETS(N_SETS)) u_top (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_pend_i (set_pend),
    .intx_lvl_i (intx_lvl),
    .en_wr_i    (reg_we_i && reg_addr_i == TOP_EN_OFS),
    .st_wr_i    (reg_we_i && reg_addr_i == TOP_ST_OFS),
    .wdata_i    (reg_wdata_i),
    .top_st_o   (top_st),
    .top_en_o   (top_en),
    .irq_o      (irq_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == TOP_EN_OFS) reg_rdata_o = top_en;
    if (reg_addr_i == TOP_ST_OFS) reg_rdata_o = top_st;
    if (reg_addr_i == SET_EN_OFS) reg_rdata_o = REG_DW'(set_en_q);
    for (int unsigned i = 0; i < N_SETS; i++) begin
      if (reg_addr_i == SET_BASE_OFS + REG_AW'(SET_STRIDE * i))     reg_rdata_o = lo[i];
      if (reg_addr_i == SET_BASE_OFS + REG_AW'(SET_STRIDE * i + 4)) reg_rdata_o = REG_DW'(stat[i]);
      if (reg_addr_i == SET_BASE_OFS + REG_AW'(SET_STRIDE * i + 8)) reg_rdata_o = REG_DW'(ena[i]);
      if (reg_addr_i == HI_BASE_OFS + REG_AW'(HI_STRIDE * i))       reg_rdata_o = hi[i];
    end
  end
endmodule

// File: rtl/msi_irq_agg_chk.sv
module msi_irq_agg_chk
  import msi_agg_pkg::*;
#(
  parameter int unsigned N_SETS = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            msi_valid_i,
  input logic                            irq_o,
  input logic [REG_DW-1:0]               top_st,
  input logic [REG_DW-1:0]               top_en,
  input logic [N_SETS*VEC_PER_SET-1:0]   stat_flat,
  input logic [INTX_NUM-1:0]             intx_lvl,
  input logic [N_SETS-1:0]               set_clr
);
  assert_capture_needs_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(stat_flat & ~$past(stat_flat))) |-> $past(msi_valid_i));

  assert_top_clear_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|set_clr) |=> ((top_st[SET_LSB_POS +: N_SETS] & $past(set_clr)) == '0));

  assert_intx_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((top_st[INTX_LSB_POS +: INTX_NUM] & $past(intx_lvl)) == $past(intx_lvl)));

  assert_irq_follows_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == $past(|(top_st & top_en)));
endmodule

bind msi_irq_agg msi_irq_agg_chk #(.N_SETS(N_SETS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .msi_valid_i (msi_valid_i),
  .irq_o       (irq_o),
  .top_st      (top_st),
  .top_en      (top_en),
  .stat_flat   (stat_flat),
  .intx_lvl    (intx_lvl),
  .set_clr     (set_clr)
);

// File: tb/sim_msi_irq_agg.sv
`timescale 1ns/1ps
module sim_msi_irq_agg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msi_valid = 1'b0;
  logic [63:0] msi_addr = '0;
  logic [31:0] msi_data = '0;
  logic [3:0]  intx_as = '0;
  logic [3:0]  intx_de = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  bit rd_vld = 1'b0;

  typedef struct {
    bit          is_irq;
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbq[$];
  item_t it;
  logic [31:0] act;

  always #10 clk = ~clk;

  msi_irq_agg u0 (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .reg_we_i        (reg_we),
    .reg_addr_i      (reg_addr),
    .reg_wdata_i     (reg_wdata),
    .reg_rdata_o     (reg_rdata),
    .msi_valid_i     (msi_valid),
    .msi_addr_i      (msi_addr),
    .msi_data_i      (msi_data),
    .intx_assert_i   (intx_as),
    .intx_deassert_i (intx_de),
    .irq_o           (irq)
  );

  // monitor: compares one queued item per flagged cycle
  always @(negedge clk) begin
    if (rd_vld && sbq.size() > 0) begin
      it = sbq.pop_front();
      act = it.is_irq ? {31'b0, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    step();
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_we = 1'b0;
  endtask

  task automatic msi(input logic [63:0] a, input logic [31:0] d);
    step();
    msi_valid = 1'b1; msi_addr = a; msi_data = d;
    step();
    msi_valid = 1'b0;
  endtask

  task automatic chk_reg(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t x;
    x.is_irq = 1'b0; x.addr = a; x.exp = e; x.tag = tag;
    reg_addr = a;
    sbq.push_back(x);
    rd_vld = 1'b1;
    step();
    rd_vld = 1'b0;
  endtask

  task automatic chk_irq(input bit e, input string tag);
    item_t x;
    x.is_irq = 1'b1; x.addr = '0; x.exp = {31'b0, e}; x.tag = tag;
    sbq.push_back(x);
    rd_vld = 1'b1;
    step();
    rd_vld = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    step();

    // R1 reset state
    chk_reg(12'h184, 32'h0, "R1");
    chk_reg(12'h190, 32'h0, "R1");
    chk_reg(12'hC24, 32'h0, "R1");
    chk_irq(1'b0, "R1");

    // R10 capture address programming
    wr(12'hC20, 32'h1000_0020);
    wr(12'hC88, 32'h0000_0001);
    wr(12'hC50, 32'h2000_0050);
    wr(12'hC94, 32'h0000_0000);
    chk_reg(12'hC20, 32'h1000_0020, "R10");
    chk_reg(12'hC88, 32'h0000_0001, "R10");

    // R3 set disabled: dropped
    msi({32'h1, 32'h1000_0020}, 32'h3);
    chk_reg(12'hC24, 32'h0, "R3");

    // R9 enable masks
    wr(12'h190, 32'hFFFF_FFFF);
    chk_reg(12'h190, 32'h0000_00FF, "R9");
    wr(12'h180, 32'hFFFF_FFFF);
    chk_reg(12'h180, 32'h0F00_FF00, "R9");

    // R2 capture, data 0x23 -> vector 3
    msi({32'h1, 32'h1000_0020}, 32'h23);
    chk_reg(12'hC24, 32'h0000_0008, "R2");
    // R5 vector enable zero: no summary
    chk_reg(12'h184, 32'h0, "R5");
    // R3 high word mismatch
    msi({32'h2, 32'h1000_0020}, 32'h1);
    chk_reg(12'hC24, 32'h0000_0008, "R3");

    // R5 enable vector 3 -> summary bit 10
    wr(12'hC28, 32'h0000_0008);
    step();
    chk_reg(12'h184, 32'h0000_0400, "R5");
    chk_irq(1'b1, "R8");

    // R6 clear while still pending: one cycle low then back
    wr(12'h184, 32'h0000_0400);
    chk_reg(12'h184, 32'h0, "R6");
    chk_reg(12'h184, 32'h0000_0400, "R6");

    // R4 clear status, then summary clear sticks
    wr(12'hC24, 32'h0000_0008);
    chk_reg(12'hC24, 32'h0, "R4");
    wr(12'h184, 32'h0000_0400);
    chk_reg(12'h184, 32'h0, "R6");
    chk_reg(12'h184, 32'h0, "R6");
    chk_irq(1'b0, "R8");

    // R4 capture wins over same-edge clear
    step();
    reg_we = 1'b1; reg_addr = 12'hC24; reg_wdata = 32'h8;
    msi_valid = 1'b1; msi_addr = {32'h1, 32'h1000_0020}; msi_data = 32'h3;
    step();
    reg_we = 1'b0; msi_valid = 1'b0;
    chk_reg(12'hC24, 32'h0000_0008, "R4");
    wr(12'hC24, 32'h0000_0008);
    wr(12'h184, 32'h0000_0400);
    chk_reg(12'h184, 32'h0, "R4");

    // R8 summary set but its enable off
    wr(12'h180, 32'h0F00_DF00);
    wr(12'hC58, 32'h8000_0000);
    msi({32'h0, 32'h2000_0050}, 32'h3F);
    chk_reg(12'hC54, 32'h8000_0000, "R2");
    chk_reg(12'h184, 32'h0000_2000, "R5");
    chk_irq(1'b0, "R8");
    wr(12'h180, 32'h0F00_FF00);
    chk_reg(12'h180, 32'h0F00_FF00, "R9");
    chk_irq(1'b1, "R8");
    wr(12'hC54, 32'h8000_0000);
    wr(12'h184, 32'h0000_2000);
    chk_reg(12'h184, 32'h0, "R6");
    chk_irq(1'b0, "R8");

    // R7 level source INTB
    step();
    intx_as = 4'b0010;
    step();
    intx_as = 4'b0000;
    step();
    chk_reg(12'h184, 32'h0200_0000, "R7");
    chk_irq(1'b1, "R7");
    wr(12'h184, 32'h0200_0000);
    chk_reg(12'h184, 32'h0200_0000, "R7");
    step();
    intx_de = 4'b0010;
    step();
    intx_de = 4'b0000;
    step();
    chk_reg(12'h184, 32'h0200_0000, "R7");
    wr(12'h184, 32'h0200_0000);
    chk_reg(12'h184, 32'h0, "R7");
    chk_irq(1'b0, "R7");

    repeat (2) step();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule